// File: doc/BRIEF.md
# Dual-Mode Timer

This block is a register-programmed timer with one configuration value that decides how it behaves. Configured one way, it is a 32-bit down-counter. It loads from a programmable value, decrements once per enabled clock cycle and raises a timeout event. It either stops after that event or reloads and runs again. Configured the other way, it is a 32-bit seconds counter. It advances on an external once-per-second strobe and wraps to zero once it would pass a programmed match value.

The load and match values are each held as two 16-bit halves. When a 32-bit mode is selected, one write to the A register fills both halves. When a split mode is selected, each half is written on its own, and split modes do no counting at all. Events collect in a raw status register, which is gated by a mask register and cleared by writing ones. A single registered level interrupt is high while any unmasked event is pending. An optional one-cycle trigger pulse accompanies each countdown timeout.

Top module: `dual_timer`

## Requirements
- R1: Registers sit at these byte offsets: configuration 0x00, control 0x04, mode A 0x08, mode B 0x0C, load A 0x10, load B 0x14, match A 0x18, match B 0x1C, prescale A 0x20, prescale B 0x24, prescale-match A 0x28, prescale-match B 0x2C, interrupt mask 0x30, raw status 0x34, masked status 0x38, event clear 0x3C, counter A 0x40, counter B 0x44. A read presented in one cycle appears on bus_rdata after the next rising clock edge. After reset every register reads 0, and irq and trig_out are low.
- R2: When the configuration value is below 4, a write to load A stores bits 15:0 in the A half and bits 31:16 in the B half, and a read of load A returns {B half, A half}. A write to load B stores its bits 15:0 in the B half, and a read of load B returns the B half. Match A and match B follow the same rules.
- R3: When the configuration value is 4 or more, a write to load A changes only the A half, and a read of load A returns the A half with bits 31:16 zero.
- R4: With configuration 0, a 0-to-1 change of control bit 0 loads the counter from the 32-bit load value. The counter then decrements on each clock edge at which tick_en is high, and a timeout occurs at the edge where it passes from 1 to 0. With tick_en held high, this is the L-th edge after the write edge for a load value L. Edges with tick_en low do not count.
- R5: If mode A bit 0 is 1 (one-shot), a timeout clears control bit 0, and no further timeouts occur.
- R6: If mode A bit 0 is 0 (periodic), the counter reloads at each timeout, so timeouts repeat every L counted ticks.
- R7: A timeout sets raw status bit 0. If control bit 5 is set, trig_out is high for exactly the one cycle after the timeout edge. If control bit 5 is clear, trig_out stays low.
- R8: With configuration 1 and control bit 0 set, each sec_strobe edge increments the seconds counter. An increment that would exceed the 32-bit match value wraps the counter to 0 and sets raw status bit 3. Counter A reads the seconds counter only in configuration 1 and reads 0 otherwise. Counter B always reads 0.
- R9: The interrupt mask keeps only the bits under 0x77 of a write. Masked status reads raw AND mask. irq goes high on the edge after masked status becomes nonzero and low on the edge after it returns to zero.
- R10: A write to event clear clears every raw status bit written as 1 and leaves the others unchanged. Event clear reads 0.
- R11: With a configuration value of 4 or more, enabling either half (control bit 0 or 8) produces no timeout, no trigger and no raw status change.
- R12: Reads of unmapped offsets return 0, and writes to them change no register.
- R13: A 1-to-0 change of control bit 0 stops the countdown, so no timeout follows while it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered |
| tick_en | input | 1 | Countdown clock enable |
| sec_strobe | input | 1 | Once-per-second strobe for the seconds counter |
| irq | output | 1 | Level interrupt from masked status |
| trig_out | output | 1 | One-cycle pulse on countdown timeout when enabled |

## Verification
The hardest case to reach from the ports is the exact edge of a countdown timeout when tick_en has gaps, because the count itself cannot be read back. The stimulus therefore starts the counter with a small load value and holds tick_en low for a fixed number of edges. It then samples trig_out one cycle before and exactly at the edge the requirement predicts. It also checks the no-gap case, the one-shot and periodic pulse counts over a fixed window, and the stop on disable. The seconds wrap is reached by setting a match value of 2 and giving three strobes. The wrap event sits outside the mask bits, so the interrupt latency is checked with the timeout event instead.

// File: rtl/dual_timer_pkg.sv
package dual_timer_pkg;

  localparam int OFF_CFG     = 'h00;
  localparam int OFF_CTL     = 'h04;
  localparam int OFF_MODE_A  = 'h08;
  localparam int OFF_MODE_B  = 'h0C;
  localparam int OFF_LOAD_A  = 'h10;
  localparam int OFF_LOAD_B  = 'h14;
  localparam int OFF_MATCH_A = 'h18;
  localparam int OFF_MATCH_B = 'h1C;
  localparam int OFF_PRE_A   = 'h20;
  localparam int OFF_PRE_B   = 'h24;
  localparam int OFF_PMT_A   = 'h28;
  localparam int OFF_PMT_B   = 'h2C;
  localparam int OFF_MASK    = 'h30;
  localparam int OFF_RAW     = 'h34;
  localparam int OFF_MIS     = 'h38;
  localparam int OFF_CLR     = 'h3C;
  localparam int OFF_CNT_A   = 'h40;

  localparam int CTL_EN_A  = 0;
  localparam int CTL_TRIG  = 5;
  localparam int RAW_TMO   = 0;
  localparam int RAW_RTC   = 3;
  localparam int MASK_KEEP = 'h77;
  localparam int CFG_SPLIT = 4;

  typedef enum logic [1:0] {
    MD_DOWN  = 2'd0,
    MD_RTC   = 2'd1,
    MD_SPLIT = 2'd2,
    MD_OTHER = 2'd3
  } tmr_mode_e;

endpackage

// File: rtl/dual_timer_halves.sv
module dual_timer_halves #(
  parameter int HALF_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_a,
  input  logic                  wr_b,
  input  logic                  joined,
  input  logic [2*HALF_W-1:0]   wdata,
  output logic [HALF_W-1:0]     lo,
  output logic [HALF_W-1:0]     hi
);

  always_ff @(posedge clk) begin
    if (rst) begin
      lo <= '0;
      hi <= '0;
    end else if (wr_a) begin
      lo <= wdata[HALF_W-1:0];
      if (joined) hi <= wdata[2*HALF_W-1:HALF_W];
    end else if (wr_b) begin
      hi <= wdata[HALF_W-1:0];
    end
  end

endmodule

// File: rtl/dual_timer_down.sv
module dual_timer_down #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         run,
  input  logic         tick,
  input  logic [W-1:0] reload,
  output logic         timeout
);

  logic [W-1:0] cnt_q;

  // Passing from 1 to 0 on a counted edge is the timeout.
  assign timeout = run && tick && (cnt_q == W'(1));

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (start)        cnt_q <= reload;
    else if (run && tick)  cnt_q <= timeout ? reload : cnt_q - W'(1);
  end

endmodule

// File: rtl/dual_timer_sec.sv
module dual_timer_sec #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         strobe,
  input  logic [W-1:0] limit,
  output logic [W-1:0] cnt,
  output logic         wrap
);

  logic [W:0] nxt;

  assign nxt  = {1'b0, cnt} + (W+1)'(1);
  assign wrap = run && strobe && (nxt > {1'b0, limit});

  always_ff @(posedge clk) begin
    if (rst)                  cnt <= '0;
    else if (wrap)            cnt <= '0;
    else if (run && strobe)   cnt <= nxt[W-1:0];
  end

endmodule

// File: rtl/dual_timer.sv
module dual_timer
  import dual_timer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CFG_W  = 3,
  parameter int MODE_W = 8,
  parameter int PRE_W  = 8,
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick_en,
  input  logic              sec_strobe,
  output logic              irq,
  output logic              trig_out
);

  localparam int HALF_W = DATA_W / 2;

  logic [CFG_W-1:0]  cfg_q;
  logic [MODE_W-1:0] mode_a_q, mode_b_q;
  logic [DATA_W-1:0] ctl_q;
  logic [STAT_W-1:0] mask_q, raw_q, raw_nxt;
  logic [1:0][PRE_W-1:0] pre_q, pmt_q;
  logic [DATA_W-1:0] rdata_q, rd_mux;
  logic              irq_q, trig_q;

  logic [31:0] addr_i;
  logic        wen, ren, ctl_wr, clr_wr, joined;
  tmr_mode_e   mode;
  logic        start_a, run_down, run_rtc, tmo_a, rtc_wrap;
  logic [DATA_W-1:0] rtc_cnt;
  logic [1:0][HALF_W-1:0] half_lo, half_hi;

  assign addr_i = 32'(bus_addr);
  assign wen    = bus_sel && bus_wr;
  assign ren    = bus_sel && !bus_wr;
  assign ctl_wr = wen && (addr_i == OFF_CTL);
  assign clr_wr = wen && (addr_i == OFF_CLR);

  always_comb begin
    if (int'(cfg_q) == 0)              mode = MD_DOWN;
    else if (int'(cfg_q) == 1)         mode = MD_RTC;
    else if (int'(cfg_q) >= CFG_SPLIT) mode = MD_SPLIT;
    else                               mode = MD_OTHER;
  end
  assign joined = (int'(cfg_q) < CFG_SPLIT);

  // Load (index 0) and match (index 1) register pairs.
  for (genvar g = 0; g < 2; g++) begin : g_pair
    localparam int OA = (g == 0) ? OFF_LOAD_A : OFF_MATCH_A;
    localparam int OB = (g == 0) ? OFF_LOAD_B : OFF_MATCH_B;
    dual_timer_halves #(.HALF_W(HALF_W)) u_pair (
      .clk    (clk),
      .rst    (rst),
      .wr_a   (wen && (addr_i == OA)),
      .wr_b   (wen && (addr_i == OB)),
      .joined (joined),
      .wdata  (bus_wdata),
      .lo     (half_lo[g]),
      .hi     (half_hi[g])
    );
  end

  assign start_a  = ctl_wr && bus_wdata[CTL_EN_A] && !ctl_q[CTL_EN_A] && (mode == MD_DOWN);
  assign run_down = ctl_q[CTL_EN_A] && (mode == MD_DOWN);
  assign run_rtc  = ctl_q[CTL_EN_A] && (mode == MD_RTC);

  dual_timer_down #(.W(DATA_W)) u_down (
    .clk     (clk),
    .rst     (rst),
    .start   (start_a),
    .run     (run_down),
    .tick    (tick_en),
    .reload  ({half_hi[0], half_lo[0]}),
    .timeout (tmo_a)
  );

  dual_timer_sec #(.W(DATA_W)) u_sec (
    .clk    (clk),
    .rst    (rst),
    .run    (run_rtc),
    .strobe (sec_strobe),
    .limit  ({half_hi[1], half_lo[1]}),
    .cnt    (rtc_cnt),
    .wrap   (rtc_wrap)
  );

  // Event setting wins over a clear in the same cycle.
  always_comb begin
    raw_nxt = raw_q;
    if (clr_wr)   raw_nxt = raw_q & ~bus_wdata[STAT_W-1:0];
    if (tmo_a)    raw_nxt[RAW_TMO] = 1'b1;
    if (rtc_wrap) raw_nxt[RAW_RTC] = 1'b1;
  end

  always_comb begin
    case (addr_i)
      OFF_CFG:     rd_mux = DATA_W'(cfg_q);
      OFF_CTL:     rd_mux = ctl_q;
      OFF_MODE_A:  rd_mux = DATA_W'(mode_a_q);
      OFF_MODE_B:  rd_mux = DATA_W'(mode_b_q);
      OFF_LOAD_A:  rd_mux = {joined ? half_hi[0] : {HALF_W{1'b0}}, half_lo[0]};
      OFF_LOAD_B:  rd_mux = {{HALF_W{1'b0}}, half_hi[0]};
      OFF_MATCH_A: rd_mux = {joined ? half_hi[1] : {HALF_W{1'b0}}, half_lo[1]};
      OFF_MATCH_B: rd_mux = {{HALF_W{1'b0}}, half_hi[1]};
      OFF_PRE_A:   rd_mux = DATA_W'(pre_q[0]);
      OFF_PRE_B:   rd_mux = DATA_W'(pre_q[1]);
      OFF_PMT_A:   rd_mux = DATA_W'(pmt_q[0]);
      OFF_PMT_B:   rd_mux = DATA_W'(pmt_q[1]);
      OFF_MASK:    rd_mux = DATA_W'(mask_q);
      OFF_RAW:     rd_mux = DATA_W'(raw_q);
      OFF_MIS:     rd_mux = DATA_W'(raw_q & mask_q);
      OFF_CNT_A:   rd_mux = (mode == MD_RTC) ? rtc_cnt : '0;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q    <= '0;
      mode_a_q <= '0;
      mode_b_q <= '0;
      ctl_q    <= '0;
      mask_q   <= '0;
      raw_q    <= '0;
      pre_q    <= '0;
      pmt_q    <= '0;
      rdata_q  <= '0;
      irq_q    <= 1'b0;
      trig_q   <= 1'b0;
    end else begin
      if (wen) begin
        case (addr_i)
          OFF_CFG:    cfg_q    <= bus_wdata[CFG_W-1:0];
          OFF_MODE_A: mode_a_q <= bus_wdata[MODE_W-1:0];
          OFF_MODE_B: mode_b_q <= bus_wdata[MODE_W-1:0];
          OFF_PRE_A:  pre_q[0] <= bus_wdata[PRE_W-1:0];
          OFF_PRE_B:  pre_q[1] <= bus_wdata[PRE_W-1:0];
          OFF_PMT_A:  pmt_q[0] <= bus_wdata[PRE_W-1:0];
          OFF_PMT_B:  pmt_q[1] <= bus_wdata[PRE_W-1:0];
          OFF_MASK:   mask_q   <= bus_wdata[STAT_W-1:0] & STAT_W'(MASK_KEEP);
          default: ;
        endcase
      end
      if (ctl_wr)                      ctl_q <= bus_wdata;
      else if (tmo_a && mode_a_q[0])   ctl_q[CTL_EN_A] <= 1'b0;
      raw_q  <= raw_nxt;
      irq_q  <= |(raw_q & mask_q);
      trig_q <= tmo_a && ctl_q[CTL_TRIG];
      if (ren) rdata_q <= rd_mux;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = irq_q;
  assign trig_out  = trig_q;

endmodule

// File: rtl/dual_timer_chk.sv
module dual_timer_chk
  import dual_timer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CFG_W  = 3,
  parameter int STAT_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              wdata_b0,
  input logic              ctl_en,
  input logic              ctl_trig,
  input logic              oneshot,
  input logic              raw_tmo,
  input logic [STAT_W-1:0] mask_q,
  input logic [CFG_W-1:0]  cfg_q,
  input logic              tmo_a,
  input logic              rtc_wrap,
  input logic              irq,
  input logic              trig_out
);

  logic wr_ctl, wr_clr;
  assign wr_ctl = bus_sel && bus_wr && (32'(bus_addr) == OFF_CTL);
  assign wr_clr = bus_sel && bus_wr && (32'(bus_addr) == OFF_CLR);

  // R7: a trigger pulse always comes with the timeout status bit
  a_r7_trig_has_status: assert property (@(posedge clk) disable iff (rst)
    trig_out |-> raw_tmo);

  // R7: a trigger pulse needs the trigger enable in the cycle before
  a_r7_trig_needs_enable: assert property (@(posedge clk) disable iff (rst)
    trig_out |-> $past(ctl_trig));

  // R5: one-shot timeout drops the enable
  a_r5_oneshot_stops: assert property (@(posedge clk) disable iff (rst)
    (tmo_a && oneshot && !wr_ctl) |=> !ctl_en);

  // R11: split configurations produce no events
  a_r11_split_quiet: assert property (@(posedge clk) disable iff (rst)
    (int'(cfg_q) >= CFG_SPLIT) |-> (!tmo_a && !rtc_wrap));

  // R10: clearing bit 0 with no new timeout leaves it low
  a_r10_clear_works: assert property (@(posedge clk) disable iff (rst)
    (wr_clr && wdata_b0 && !tmo_a) |=> !raw_tmo);

  // R9: with an all-zero mask the interrupt stays low
  a_r9_irq_masked: assert property (@(posedge clk) disable iff (rst)
    ($past(mask_q) == '0) |-> !irq);

  // R13: with the enable low no timeout happens
  a_r13_stopped_quiet: assert property (@(posedge clk) disable iff (rst)
    (!ctl_en && !$past(ctl_en)) |-> !tmo_a);

endmodule

bind dual_timer dual_timer_chk #(
  .ADDR_W (ADDR_W),
  .CFG_W  (CFG_W),
  .STAT_W (STAT_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_sel  (bus_sel),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .wdata_b0 (bus_wdata[0]),
  .ctl_en   (ctl_q[0]),
  .ctl_trig (ctl_q[5]),
  .oneshot  (mode_a_q[0]),
  .raw_tmo  (raw_q[0]),
  .mask_q   (mask_q),
  .cfg_q    (cfg_q),
  .tmo_a    (tmo_a),
  .rtc_wrap (rtc_wrap),
  .irq      (irq),
  .trig_out (trig_out)
);

// File: tb/sim_dual_timer.sv
`timescale 1ns/100ps
module sim_dual_timer;

  localparam int A_CFG = 'h00, A_CTL = 'h04, A_MODEA = 'h08, A_LOADA = 'h10,
                 A_LOADB = 'h14, A_MATCHA = 'h18, A_MASK = 'h30, A_RAW = 'h34,
                 A_MIS = 'h38, A_CLR = 'h3C, A_CNTA = 'h40, A_CNTB = 'h44;

  logic        clk = 1'b0, rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        tick_en = 1'b1, sec_strobe = 1'b0;
  logic        irq, trig_out;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  logic rd_lat = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  dual_timer u0 (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_en(tick_en), .sec_strobe(sec_strobe), .irq(irq), .trig_out(trig_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_lat <= bus_sel && !bus_wr;

  // Monitor: compares each captured read against the scoreboard queue.
  always @(negedge clk) begin
    if (rd_lat && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, bus_rdata, e);
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'(a); bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'(a);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic strobe();
    @(negedge clk); sec_strobe = 1'b1;
    @(negedge clk); sec_strobe = 1'b0;
  endtask

  task automatic count_pulses(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      if (trig_out) cnt++;
      @(negedge clk);
    end
  endtask

  task automatic quiesce();
    wr(A_CTL, 32'h0);
    wr(A_CLR, 32'hFF);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_up();
  end

  initial begin
    int p;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 irq after reset", 32'(irq), 0);
    chk("R1 trig after reset", 32'(trig_out), 0);
    rd(A_CTL, 0, "R1 control after reset");
    rd(A_LOADA, 0, "R1 load after reset");
    rd(A_RAW, 0, "R1 raw after reset");

    // R12 unmapped offset
    wr('h80, 32'hFFFF_FFFF);
    rd('h80, 0, "R12 unmapped read");
    rd(A_CFG, 0, "R12 cfg untouched");
    rd(A_MASK, 0, "R12 mask untouched");

    // R2 joined halves
    wr(A_LOADA, 32'h1234_5678);
    rd(A_LOADA, 32'h1234_5678, "R2 load A combined");
    rd(A_LOADB, 32'h0000_1234, "R2 load B upper half");
    wr(A_LOADB, 32'h0000_ABCD);
    rd(A_LOADA, 32'hABCD_5678, "R2 load B write seen in A");
    wr(A_MATCHA, 32'h0055_00AA);
    rd(A_MATCHA, 32'h0055_00AA, "R2 match A combined");

    // R3 split halves
    wr(A_CFG, 4);
    wr(A_LOADA, 32'h9999_0001);
    rd(A_LOADA, 32'h0000_0001, "R3 load A low only");
    rd(A_LOADB, 32'h0000_ABCD, "R3 B half kept");

    // R4 exact timeout edge, tick_en high, L=5
    wr(A_CFG, 0);
    wr(A_MODEA, 0);
    wr(A_LOADA, 5);
    wr(A_CTL, 32'h21);
    repeat (4) @(negedge clk);
    chk("R4 no pulse before edge L", 32'(trig_out), 0);
    @(negedge clk);
    chk("R4 R7 pulse at edge L", 32'(trig_out), 1);
    @(negedge clk);
    chk("R7 pulse lasts one cycle", 32'(trig_out), 0);
    quiesce();

    // R4 tick_en gaps, L=4
    wr(A_LOADA, 4);
    wr(A_CTL, 32'h21);
    tick_en = 1'b0;
    repeat (6) @(negedge clk);
    tick_en = 1'b1;
    repeat (3) @(negedge clk);
    chk("R4 paused edges not counted", 32'(trig_out), 0);
    @(negedge clk);
    chk("R4 timeout after counted ticks", 32'(trig_out), 1);
    quiesce();

    // R6 periodic, then R13 stop
    wr(A_LOADA, 4);
    wr(A_CTL, 32'h21);
    count_pulses(13, p);
    chk("R6 periodic pulses in 12 cycles", p, 3);
    wr(A_CTL, 32'h20);
    count_pulses(12, p);
    chk("R13 no pulse after disable", p, 0);
    quiesce();

    // R7 trigger disabled
    wr(A_LOADA, 3);
    wr(A_CTL, 32'h01);
    count_pulses(10, p);
    chk("R7 no trigger when bit 5 clear", p, 0);
    rd(A_RAW, 32'h01, "R7 timeout status set");
    quiesce();

    // R5 one-shot
    wr(A_MODEA, 1);
    wr(A_LOADA, 3);
    wr(A_CTL, 32'h21);
    count_pulses(13, p);
    chk("R5 single pulse", p, 1);
    rd(A_CTL, 32'h20, "R5 enable cleared");
    rd(A_RAW, 32'h01, "R5 raw timeout");

    // R11 split: no events
    wr(A_CFG, 4);
    wr(A_CTL, 32'h121);
    count_pulses(20, p);
    chk("R11 no trigger in split", p, 0);
    rd(A_RAW, 32'h01, "R11 raw unchanged");

    // R8 seconds counter
    wr(A_CTL, 0);
    wr(A_CFG, 1);
    wr(A_MATCHA, 2);
    wr(A_CTL, 1);
    strobe();
    rd(A_CNTA, 1, "R8 count after one strobe");
    strobe();
    rd(A_CNTA, 2, "R8 count at match");
    strobe();
    rd(A_CNTA, 0, "R8 wrap to zero");
    rd(A_RAW, 32'h09, "R8 wrap status bit 3");
    rd(A_CNTB, 0, "R8 counter B zero");
    wr(A_CTL, 0);
    wr(A_CFG, 0);
    rd(A_CNTA, 0, "R8 counter A zero in countdown");

    // R9 mask and irq latency
    chk("R9 irq low while masked", 32'(irq), 0);
    wr(A_MASK, 32'hFF);
    chk("R9 irq not yet high", 32'(irq), 0);
    @(negedge clk);
    chk("R9 irq high one edge later", 32'(irq), 1);
    rd(A_MASK, 32'h77, "R9 mask kept bits");
    rd(A_MIS, 32'h01, "R9 masked status");

    // R10 clear
    wr(A_CLR, 32'h01);
    chk("R10 irq still high", 32'(irq), 1);
    @(negedge clk);
    chk("R10 irq falls after clear", 32'(irq), 0);
    rd(A_RAW, 32'h08, "R10 other bit kept");
    rd(A_CLR, 0, "R10 clear reads zero");

    repeat (4) @(negedge clk);
    finish_up();
  end

endmodule